// File: doc/BRIEF.md
# Dual-Tone Sample Synthesizer

This block turns a key selection into a stream of digital sample codes for a small external resistor-ladder D/A stage. The selection is a row index and a column index, given with a one-cycle start strobe. Each index picks one tone from a fixed set. The low-group tones are derived from the 3.579545 MHz clock by integer dividers, and so are the high-group tones. Each tone walks through a 16-step staircase sine. The two staircases are added together to form a 5-bit code. If only one index is present, only that tone is produced.

The sequencer has three states. ST_IDLE waits for a strobe. ST_TONE plays one burst of fixed length. ST_GAP holds the output silent for a fixed length and ends with a one-cycle done pulse. The transitions are:
- idle-to-tone, on a valid strobe.
- tone-to-gap, when the burst count runs out.
- gap-to-idle, when the gap count runs out and no request is waiting.
- gap-to-tone, when the gap count runs out and a request is held or arrives in that cycle.
- any-to-idle, while pulse mode is asserted.

By default both the burst and the gap last 332,898 clocks, which is about 93 ms at the nominal clock.

Top module: `dtmf_synth`

## Requirements
- R1: After reset, `code` is 0 and `tone_active` and `done` are low.
- R2: A strobe starts a burst in the cycle after it is sampled. The strobe must carry `row_sel` in 1..4 or `col_sel` in 1..3. `row_sel` values 0 and 5..7 mean no row. `col_sel` 0 means no column. A strobe with neither is dropped.
- R3: A burst keeps `tone_active` high for exactly TONE_CYC consecutive clocks.
- R4: The row tones advance one staircase step every 320, 292, 264 or 236 clocks for rows 1 to 4. At 3.579545 MHz this gives about 699, 766, 848 and 948 Hz. Each is within 0.8 % of 697, 770, 852 and 941 Hz.
- R5: The column tones advance one step every 184, 168 or 152 clocks for columns 1 to 3. This gives about 1216, 1332 and 1472 Hz, within 0.8 % of 1209, 1336 and 1477 Hz.
- R6: Both staircases start at step 0 in the first cycle of a burst. Steps 0 to 15 give the levels 8,11,13,14,15,14,13,11,8,5,3,1,0,1,3,5. `code` is the row level plus the column level.
- R7: A missing row or column adds 0, so a single tone appears alone on `code`.
- R8: After each burst, `tone_active` stays low and `code` stays 0 for GAP_CYC clocks.
- R9: `done` is high for exactly one clock, the last clock of the gap.
- R10: A strobe during a burst or a gap is held, and a later strobe replaces the held one. The held strobe starts its burst in the cycle right after `done`. A strobe in the last gap cycle is also served in the cycle right after `done`.
- R11: While `pulse_mode` is high, `code` is 0 and `tone_active` is low. Strobes are discarded and any burst or held request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally 3.579545 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_mode | input | 1 | High selects pulse dialing; forces silence |
| start | input | 1 | One-cycle request strobe |
| row_sel | input | 3 | Row index, 1..4 valid |
| col_sel | input | 2 | Column index, 1..3 valid |
| code | output | 5 | Summed sample code |
| tone_active | output | 1 | High during a burst |
| done | output | 1 | One-cycle pulse at the end of the gap |

## Verification
The end of the gap and the acceptance of a new request can fall in the same cycle. The bench provokes this by raising a strobe in exactly the last gap cycle, which is the cycle in which `done` is high. It judges the result by requiring that a new burst with the new selection starts in the very next clock. The same immediate-start rule is applied to requests held from earlier in the burst or the gap. Every burst sample is compared against a step model computed from the elapsed cycle count, so both the tone periods and the summing are checked.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int DIV_W = 9;
    localparam int PH_W  = 4;
    localparam int AMP_W = 4;
    localparam int CODE_W = AMP_W + 1;
    localparam int ROW_W = 3;
    localparam int COL_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TONE = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_t;

    // clocks per staircase step for each low-group tone
    function automatic logic [DIV_W-1:0] row_divisor(input logic [ROW_W-1:0] idx);
        logic [DIV_W-1:0] d;
        case (idx)
            3'd1:    d = 9'd320;
            3'd2:    d = 9'd292;
            3'd3:    d = 9'd264;
            3'd4:    d = 9'd236;
            default: d = 9'd1;
        endcase
        return d;
    endfunction

    // clocks per staircase step for each high-group tone
    function automatic logic [DIV_W-1:0] col_divisor(input logic [COL_W-1:0] idx);
        logic [DIV_W-1:0] d;
        case (idx)
            2'd1:    d = 9'd184;
            2'd2:    d = 9'd168;
            2'd3:    d = 9'd152;
            default: d = 9'd1;
        endcase
        return d;
    endfunction

    // 16-step staircase approximation of one sine period
    function automatic logic [AMP_W-1:0] sine_step(input logic [PH_W-1:0] ph);
        logic [AMP_W-1:0] a;
        case (ph)
            4'd0:  a = 4'd8;
            4'd1:  a = 4'd11;
            4'd2:  a = 4'd13;
            4'd3:  a = 4'd14;
            4'd4:  a = 4'd15;
            4'd5:  a = 4'd14;
            4'd6:  a = 4'd13;
            4'd7:  a = 4'd11;
            4'd8:  a = 4'd8;
            4'd9:  a = 4'd5;
            4'd10: a = 4'd3;
            4'd11: a = 4'd1;
            4'd12: a = 4'd0;
            4'd13: a = 4'd1;
            4'd14: a = 4'd3;
            default: a = 4'd5;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/dtmf_tone.sv
module dtmf_tone
    import dtmf_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int PW = PH_W,
    parameter int AW = AMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic [AW-1:0] sample
);

    logic [DW-1:0] step_cnt;
    logic [PW-1:0] phase;
    logic          wrap;

    assign wrap = (step_cnt == div - DW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt <= '0;
            phase    <= '0;
        end else if (!run) begin
            step_cnt <= '0;
            phase    <= '0;
        end else if (wrap) begin
            step_cnt <= '0;
            phase    <= phase + PW'(1);
        end else begin
            step_cnt <= step_cnt + DW'(1);
        end
    end

    always_comb begin
        sample = run ? AW'(sine_step(PH_W'(phase))) : '0;
    end

    // R6: phase moves only when the divider wraps
    p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && ($past(step_cnt) != $past(div) - DW'(1)))
        |-> (phase == $past(phase)));

    // R4: a wrap advances the phase by exactly one step
    p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && ($past(step_cnt) == $past(div) - DW'(1)))
        |-> (phase == PW'($past(phase) + PW'(1))));

endmodule

// File: rtl/dtmf_seq.sv
module dtmf_seq
    import dtmf_pkg::*;
#(
    parameter int TONE_CYC = 332898,
    parameter int GAP_CYC  = 332898
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_mode,
    input  logic             start,
    input  logic [ROW_W-1:0] row_sel,
    input  logic [COL_W-1:0] col_sel,
    output logic             run,
    output logic [ROW_W-1:0] row_idx,
    output logic [COL_W-1:0] col_idx,
    output logic             done
);

    localparam int LONGEST = (TONE_CYC > GAP_CYC) ? TONE_CYC : GAP_CYC;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] TONE_LAST = CNT_W'(TONE_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             pend;
    logic [ROW_W-1:0] pend_row;
    logic [COL_W-1:0] pend_col;
    logic             row_ok, col_ok, req_ok;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             tone_end, gap_end, entering;

    always_comb begin
        row_ok  = (row_sel >= ROW_W'(1)) && (row_sel <= ROW_W'(4));
        col_ok  = (col_sel != '0);
        req_ok  = start && !pulse_mode && (row_ok || col_ok);
        req_row = row_ok ? row_sel : '0;
        req_col = col_ok ? col_sel : '0;
        tone_end = (state == ST_TONE) && (cnt == TONE_LAST);
        gap_end  = (state == ST_GAP) && (cnt == GAP_LAST);
    end

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_ok) nxt = ST_TONE;
            ST_TONE: if (tone_end) nxt = ST_GAP;
            ST_GAP:  if (gap_end) nxt = (pend || req_ok) ? ST_TONE : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
        if (pulse_mode) nxt = ST_IDLE;
    end

    assign entering = (nxt == ST_TONE) && (state != ST_TONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // duration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               cnt <= '0;
        else if (pulse_mode || nxt != state)      cnt <= '0;
        else if (state != ST_IDLE)                cnt <= cnt + CNT_W'(1);
    end

    // held request and active selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_row <= '0;
            pend_col <= '0;
            row_idx  <= '0;
            col_idx  <= '0;
        end else if (pulse_mode) begin
            pend     <= 1'b0;
        end else if (entering) begin
            pend <= 1'b0;
            if (req_ok) begin
                row_idx <= req_row;
                col_idx <= req_col;
            end else begin
                row_idx <= pend_row;
                col_idx <= pend_col;
            end
        end else if (req_ok) begin
            pend     <= 1'b1;
            pend_row <= req_row;
            pend_col <= req_col;
        end
    end

    // outputs
    always_comb begin
        run  = (state == ST_TONE);
        done = gap_end && !pulse_mode;
    end

    // R3: a burst is not cut short while its count runs
    p_burst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || pulse_mode)
        (state == ST_TONE && cnt != TONE_LAST) |=> (state == ST_TONE));

    // R8: a burst that ends normally is followed by the gap
    p_gap_after_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_TONE && state != ST_TONE && !$past(pulse_mode))
        |-> (state == ST_GAP));

    // R9: done never lasts two clocks
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: pulse mode empties the sequencer
    p_pulse_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_mode |=> (state == ST_IDLE && !pend));

endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
    import dtmf_pkg::*;
#(
    parameter int TONE_CYC = 332898,
    parameter int GAP_CYC  = 332898
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_mode,
    input  logic              start,
    input  logic [ROW_W-1:0]  row_sel,
    input  logic [COL_W-1:0]  col_sel,
    output logic [CODE_W-1:0] code,
    output logic              tone_active,
    output logic              done
);

    logic             run;
    logic [ROW_W-1:0] row_idx;
    logic [COL_W-1:0] col_idx;
    logic [DIV_W-1:0] row_div, col_div;
    logic             row_run, col_run;
    logic [AMP_W-1:0] row_smp, col_smp;

    dtmf_seq #(.TONE_CYC(TONE_CYC), .GAP_CYC(GAP_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_mode (pulse_mode),
        .start      (start),
        .row_sel    (row_sel),
        .col_sel    (col_sel),
        .run        (run),
        .row_idx    (row_idx),
        .col_idx    (col_idx),
        .done       (done)
    );

    always_comb begin
        row_div = row_divisor(row_idx);
        col_div = col_divisor(col_idx);
        row_run = run && (row_idx != '0);
        col_run = run && (col_idx != '0);
    end

    dtmf_tone u_row (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (row_run),
        .div    (row_div),
        .sample (row_smp)
    );

    dtmf_tone u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (col_run),
        .div    (col_div),
        .sample (col_smp)
    );

    always_comb begin
        if (pulse_mode) begin
            code        = '0;
            tone_active = 1'b0;
        end else begin
            code        = CODE_W'(row_smp) + CODE_W'(col_smp);
            tone_active = run;
        end
    end

    // R7: the sum of two staircases never exceeds twice the peak level
    p_code_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
        code <= CODE_W'(30));

endmodule

// File: tb/tb_dtmf_synth.sv
module tb_dtmf_synth;

    localparam int TONE = 6000;
    localparam int GAP  = 1500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pulse_mode = 1'b0;
    logic       start = 1'b0;
    logic [2:0] row_sel = '0;
    logic [1:0] col_sel = '0;
    logic [4:0] code;
    logic       tone_active;
    logic       done;

    always #2 clk = ~clk;

    dtmf_synth #(.TONE_CYC(TONE), .GAP_CYC(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .pulse_mode(pulse_mode), .start(start),
        .row_sel(row_sel), .col_sel(col_sel),
        .code(code), .tone_active(tone_active), .done(done)
    );

    typedef struct {int r; int c; bit held;} item_t;
    item_t q[$];

    int checks = 0;
    int errors = 0;

    function automatic int lvl(input int ph);
        case (ph)
            0: return 8;  1: return 11; 2: return 13; 3: return 14;
            4: return 15; 5: return 14; 6: return 13; 7: return 11;
            8: return 8;  9: return 5;  10: return 3; 11: return 1;
            12: return 0; 13: return 1; 14: return 3; default: return 5;
        endcase
    endfunction

    function automatic int rdiv(input int r);
        case (r) 1: return 320; 2: return 292; 3: return 264; default: return 236; endcase
    endfunction

    function automatic int cdiv(input int c);
        case (c) 1: return 184; 2: return 168; default: return 152; endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor state
    bit    in_b = 0, in_gap = 0, prev_done = 0;
    int    k = 0, g = 0, mism = 0, first_act = 0, first_exp = 0;
    int    idle_bad = 0, pulse_bad = 0;
    item_t cur;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pulse_mode && (tone_active || code != 0)) pulse_bad++;
            if (tone_active) begin
                if (!in_b) begin
                    in_b = 1; k = 0; mism = 0;
                    if (q.size() == 0) begin
                        chk(0, "R2 unexpected burst", 1, 0);
                        cur = '{r:0, c:0, held:0};
                    end else begin
                        cur = q.pop_front();
                        if (cur.held) chk(prev_done, "R10 held start after done", int'(prev_done), 1);
                    end
                end
                begin
                    int e;
                    e = 0;
                    if (cur.r != 0) e += lvl((k / rdiv(cur.r)) % 16);   // R4 R6 R7
                    if (cur.c != 0) e += lvl((k / cdiv(cur.c)) % 16);   // R5 R6 R7
                    if (int'(code) != e) begin
                        if (mism == 0) begin first_act = int'(code); first_exp = e; end
                        mism++;
                    end
                end
                k++;
            end else begin
                if (code != 0) idle_bad++;
                if (in_b) begin
                    in_b = 0;
                    chk(k == TONE, "R3 burst length", k, TONE);
                    chk(mism == 0, "R6 sample codes", first_act, first_exp);
                    in_gap = 1; g = 0;
                end
                if (in_gap) begin
                    g++;
                    if (done) begin
                        chk(g == GAP, "R8 R9 gap length at done", g, GAP);
                        in_gap = 0;
                    end
                end else if (done) begin
                    chk(0, "R9 stray done", 1, 0);
                end
            end
            prev_done = done;
        end
    end

    task automatic press(input int r, input int c, input bit expect_b, input bit held);
        @(negedge clk);
        row_sel = 3'(r); col_sel = 2'(c); start = 1'b1;
        if (expect_b) q.push_back('{r:((r >= 1 && r <= 4) ? r : 0), c:c, held:held});
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_quiet();
        do @(negedge clk); while (q.size() != 0 || in_b || in_gap);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(code == 0, "R1 code", int'(code), 0);
        chk(!tone_active, "R1 tone_active", int'(tone_active), 0);
        chk(!done, "R1 done", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        press(1, 1, 1, 0); wait_quiet();   // R2 dual
        press(4, 0, 1, 0); wait_quiet();   // R4 R7 row only
        press(0, 3, 1, 0); wait_quiet();   // R5 R7 column only
        press(2, 2, 1, 0); wait_quiet();
        press(3, 3, 1, 0); wait_quiet();
        press(5, 1, 1, 0); wait_quiet();   // R2 row 5 means none
        press(1, 0, 1, 0); wait_quiet();
        press(0, 2, 1, 0); wait_quiet();

        // R2 strobe with nothing selected: no burst may appear
        press(0, 0, 0, 0);
        repeat (300) @(negedge clk);
        chk(!tone_active && q.size() == 0, "R2 empty strobe dropped", int'(tone_active), 0);

        // R10 strobe during burst
        press(1, 2, 1, 0);
        repeat (20) @(negedge clk);
        press(2, 1, 1, 1);
        wait_quiet();

        // R10 strobe during gap
        press(3, 2, 1, 0);
        do @(negedge clk); while (!in_gap);
        repeat (100) @(negedge clk);
        press(4, 3, 1, 1);
        wait_quiet();

        // R10 later strobe replaces held one
        press(1, 3, 1, 0);
        repeat (20) @(negedge clk);
        press(2, 3, 0, 0);
        repeat (20) @(negedge clk);
        press(3, 1, 1, 1);
        wait_quiet();

        // R10 strobe in the very cycle of done
        press(4, 1, 1, 0);
        do @(posedge clk); while (!(in_gap && g == GAP - 1));
        @(negedge clk);
        row_sel = 3'd2; col_sel = 2'd2; start = 1'b1;
        q.push_back('{r:2, c:2, held:1});
        @(negedge clk);
        start = 1'b0;
        wait_quiet();

        // R11 pulse mode silences and discards
        @(negedge clk);
        pulse_mode = 1'b1;
        press(1, 1, 0, 0);
        repeat (1500) @(negedge clk);
        pulse_mode = 1'b0;
        repeat (1500) @(negedge clk);
        chk(pulse_bad == 0, "R11 silent in pulse mode", pulse_bad, 0);
        chk(!tone_active && q.size() == 0, "R11 strobe discarded", int'(tone_active), 0);
        press(2, 3, 1, 0); wait_quiet();

        chk(idle_bad == 0, "R8 code zero outside bursts", idle_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule